// File: doc/BRIEF.md
# Software Write-Protect Command Controller

This block holds the software write-protect state for the lower half of a 256-byte serial memory. The serial front end shifts in a slave address and, when the address has been matched, hands the controller a one-cycle command event with the device-type nibble, the three selector bits, whether the lowest address pin is driven to a high voltage, and the level of the hardware write-protect pin. The controller decides whether to acknowledge the command and updates two flags: a revocable protect flag and a one-way lock flag.

On the memory side, every access presents its word address and direction. The controller raises a block signal for writes into the protected half while either flag is set. Reads and writes to the upper half are never blocked. Once the lock flag is set, no command is acknowledged and nothing can clear it short of a power-on reset of the model.

Top module: `wp_ctrl`

## Requirements
- R1: A command is acted on only when its type nibble `cmd_type` equals 4'b0110; any other nibble is not acknowledged and changes no flag.
- R2: With `a0_hv`=1, selector 3'b011 sets the protect flag, 3'b010 clears it and 3'b001 sets the lock flag; any other selector, or `a0_hv`=0, is not acknowledged and changes no flag.
- R3: An accepted clear command removes protection that the set command applied, and the lower half becomes writable again.
- R4: Once the lock flag is set it stays set until reset, whatever commands follow.
- R5: While `wp_pin`=1 no command is acknowledged and no flag changes.
- R6: While the lock flag is set every command is answered with `cmd_ack`=0 and changes no state.
- R7: `acc_block`=1 exactly when `acc_write`=1, `acc_addr` is below 8'h80 (MSB clear), and either flag is set; the output is combinational from the address inputs.
- R8: `acc_block` is 0 for every read (`acc_write`=0) regardless of protection state.
- R9: After reset both flags are 0, `cmd_ack_valid` is 0 and no access is blocked.
- R10: `cmd_ack_valid` is 1 in the cycle after each `cmd_valid` pulse and 0 otherwise, and `cmd_ack` carries the decision in that same cycle; an accepted set or clear is acknowledged even when it leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a matched command address |
| cmd_type | input | 4 | Device-type nibble of the address byte |
| cmd_sel | input | 3 | Selector bits of the address byte |
| a0_hv | input | 1 | High voltage detected on the lowest address pin |
| wp_pin | input | 1 | Hardware write-protect pin level (1 = high) |
| acc_addr | input | ADDR_W | Word address of the current memory access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| cmd_ack_valid | output | 1 | Acknowledge decision is present |
| cmd_ack | output | 1 | 1 = acknowledge the command |
| acc_block | output | 1 | Inhibit the current write |

## Verification
The bench builds the block with its default 8-bit address, so all 256 word addresses in both directions can be swept against an arithmetic model after each protection change. Every combination of the 16 type nibbles, 8 selectors, high-voltage flag and pin level is issued as a command, with only the lock-setting combination held back until the end so that lock behaviour is then tested against the full command space again.

// File: rtl/wp_pkg.sv
// Shared types for the write-protect controller.
// Assumes: the serial front end delivers address bytes already split into fields.
package wp_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_LOCK  = 2'd3
    } wp_op_e;

    localparam logic [3:0] WP_TYPE_CODE = 4'b0110;
    localparam logic [2:0] SEL_LOCK     = 3'b001;
    localparam logic [2:0] SEL_CLEAR    = 3'b010;
    localparam logic [2:0] SEL_SET      = 3'b011;
endpackage

// File: rtl/wp_cmd_decode.sv
// Turns the fields of a matched address byte into a protect operation.
// Assumes: fields are stable while the command strobe is high; purely combinational.
module wp_cmd_decode
    import wp_pkg::*;
(
    input  logic [3:0] cmd_type,
    input  logic [2:0] cmd_sel,
    input  logic       a0_hv,
    output wp_op_e     op
);
    // Map type, selector and high-voltage flag to one operation.
    always_comb begin
        op = OP_NONE;
        if (cmd_type == WP_TYPE_CODE && a0_hv) begin
            unique case (cmd_sel)
                SEL_LOCK:  op = OP_LOCK;
                SEL_SET:   op = OP_SET;
                SEL_CLEAR: op = OP_CLEAR;
                default:   op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/wp_flag_regs.sv
// Holds the protect and lock flags and registers the acknowledge decision.
// Assumes: cmd_valid is a single-cycle strobe; the lock flag is one-way.
module wp_flag_regs
    import wp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_valid,
    input  wp_op_e op,
    input  logic   wp_pin,
    output logic   set_q,
    output logic   lock_q,
    output logic   ack_valid,
    output logic   ack
);
    logic accept;

    // A command is taken when decoded, the pin is low and the lock is clear.
    always_comb accept = cmd_valid && (op != OP_NONE) && !wp_pin && !lock_q;

    // Update flags and present the acknowledge one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q     <= 1'b0;
            lock_q    <= 1'b0;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
        end else begin
            ack_valid <= cmd_valid;
            ack       <= accept;
            if (accept) begin
                unique case (op)
                    OP_SET:   set_q  <= 1'b1;
                    OP_CLEAR: set_q  <= 1'b0;
                    OP_LOCK:  lock_q <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    // R4: the lock never drops while out of reset
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R5: pin high freezes both flags and refuses the command
    a_r5_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && wp_pin) |=> (ack_valid && !ack && $stable(set_q) && $stable(lock_q)));

    // R6: lock set means no acknowledge and no protect change
    a_r6_locked_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && lock_q) |=> (!ack && $stable(set_q)));

    // R3: an accepted clear leaves the protect flag low
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_CLEAR && !wp_pin && !lock_q) |=> (ack && !set_q));

    // R10: acknowledge only alongside its valid, valid only after a strobe
    a_r10_ack_framing: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(cmd_valid));
    a_r10_ack_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ack_valid);
endmodule

// File: rtl/wp_write_gate.sv
// Blocks writes into the lower half of the address space while protected.
// Assumes: the protected region is every address with the MSB clear.
module wp_write_gate #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              set_q,
    input  logic              lock_q,
    output logic              acc_block
);
    localparam int MSB = ADDR_W - 1;

    logic in_low_half;

    // Gate a write that falls into the protected half.
    always_comb begin
        in_low_half = !acc_addr[MSB];
        acc_block   = acc_write && in_low_half && (set_q || lock_q);
    end

    // R8: reads pass whatever the flags hold
    a_r8_read_free: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_write |-> !acc_block);

    // R7: upper half is never gated
    a_r7_upper_free: assert property (@(posedge clk) disable iff (!rst_n)
        acc_addr[MSB] |-> !acc_block);
endmodule

// File: rtl/wp_ctrl.sv
// Top of the software write-protect controller: decode, flags, write gate.
// Assumes: one command strobe per matched address byte; accesses are qualified outside.
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_type,
    input  logic [2:0]        cmd_sel,
    input  logic              a0_hv,
    input  logic              wp_pin,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              cmd_ack_valid,
    output logic              cmd_ack,
    output logic              acc_block
);
    wp_op_e op;
    logic   set_q;
    logic   lock_q;

    wp_cmd_decode u_dec (
        .cmd_type (cmd_type),
        .cmd_sel  (cmd_sel),
        .a0_hv    (a0_hv),
        .op       (op)
    );

    wp_flag_regs u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op        (op),
        .wp_pin    (wp_pin),
        .set_q     (set_q),
        .lock_q    (lock_q),
        .ack_valid (cmd_ack_valid),
        .ack       (cmd_ack)
    );

    wp_write_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .set_q     (set_q),
        .lock_q    (lock_q),
        .acc_block (acc_block)
    );

    // R1: a wrong type nibble is never acknowledged
    a_r1_type_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type != WP_TYPE_CODE) |=> !cmd_ack);

    // R2: without high voltage nothing is acknowledged
    a_r2_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !a0_hv) |=> !cmd_ack);
endmodule

// File: tb/tb_wp_ctrl.sv
`timescale 1ns/1ps
module tb_wp_ctrl;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_type = '0;
    logic [2:0]        cmd_sel = '0;
    logic              a0_hv = 1'b0;
    logic              wp_pin = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_write = 1'b0;
    logic              cmd_ack_valid, cmd_ack, acc_block;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;
    bit  m_set = 0;
    bit  m_lock = 0;

    always #2.5 clk = ~clk;

    wp_ctrl #(.ADDR_W(ADDR_W)) dut (.*);

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic gate(input int addr, input bit wr, input string rq);
        bit exp;
        acc_addr  = addr[ADDR_W-1:0];
        acc_write = wr;
        #1;
        exp = wr && (m_set || m_lock) && (addr < 128);
        check(acc_block === exp, rq, int'(acc_block), int'(exp));
    endtask

    task automatic sweep_addr(input string rq);
        for (int a = 0; a < 256; a++) begin
            gate(a, 1'b1, rq);
            gate(a, 1'b0, "R8");
        end
    endtask

    task automatic cmd(input int t, input int s, input bit hv, input bit wp, input string rq);
        bit exp;
        exp = (t == 6) && hv && !wp && !m_lock && (s == 1 || s == 2 || s == 3);
        @(negedge clk);
        cmd_type = t[3:0]; cmd_sel = s[2:0]; a0_hv = hv; wp_pin = wp; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ack_valid === 1'b1, "R10", int'(cmd_ack_valid), 1);
        check(cmd_ack === exp, rq, int'(cmd_ack), int'(exp));
        if (exp) begin
            if (s == 3) m_set = 1;
            if (s == 2) m_set = 0;
            if (s == 1) m_lock = 1;
        end
        gate(8'h00, 1'b1, rq);
        gate(8'h7F, 1'b1, rq);
        gate(8'h80, 1'b1, "R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        @(negedge clk);
        check(cmd_ack_valid === 1'b0, "R9", int'(cmd_ack_valid), 0);
        sweep_addr("R9");
        // R2 / R3: set then clear, including repeated operations (R10)
        cmd(6, 3, 1, 0, "R2");
        sweep_addr("R7");
        cmd(6, 3, 1, 0, "R10");
        cmd(6, 2, 1, 0, "R3");
        sweep_addr("R3");
        cmd(6, 2, 1, 0, "R10");
        // R10: idle cycle carries no acknowledge
        @(negedge clk);
        check(cmd_ack_valid === 1'b0, "R10", int'(cmd_ack_valid), 0);
        cmd(6, 3, 1, 0, "R2");
        // R5: pin high refuses clear
        cmd(6, 2, 1, 1, "R5");
        // Full command space except the lock-setting one
        for (int t = 0; t < 16; t++)
            for (int s = 0; s < 8; s++)
                for (int h = 0; h < 2; h++)
                    for (int w = 0; w < 2; w++) begin
                        string rq;
                        if (t == 6 && s == 1 && h == 1 && w == 0) continue;
                        if (t != 6)                    rq = "R1";
                        else if (h == 0)               rq = "R2";
                        else if (w == 1)               rq = "R5";
                        else if (s == 2)               rq = "R3";
                        else                           rq = "R2";
                        cmd(t, s, h[0], w[0], rq);
                    end
        // R4: lock, then try to undo it
        cmd(6, 2, 1, 0, "R3");
        cmd(6, 1, 1, 0, "R4");
        sweep_addr("R4");
        for (int t = 0; t < 16; t++)
            for (int s = 0; s < 8; s++)
                for (int h = 0; h < 2; h++)
                    cmd(t, s, h[0], 1'b0, (t == 6) ? "R6" : "R1");
        sweep_addr("R4");
        // R9: reset clears both flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_set = 0; m_lock = 0;
        check(cmd_ack_valid === 1'b0, "R9", int'(cmd_ack_valid), 0);
        sweep_addr("R9");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule